// File: doc/BRIEF.md
# In-Place Row-Shift Address Generator

This block drives the single address port of a 16-byte state RAM. The RAM is organised column by column: location = 4·column + row. Each strobe cycle reads one byte of the stored frame in row-shifted order. In the same cycle, the matching byte of the next frame is written into the location that was just read. No second buffer is needed, because each location is refilled as soon as it has been read.

Each frame therefore lands in the RAM under the mapping used to read the frame before it, so the layout changes from frame to frame. The generator keeps a byte counter and a frame phase. The address is the row-shift permutation applied `phase` times to the byte index. Applying that permutation four times gives the identity, so the pattern repeats every four frames. The frame written right after reset goes in at natural addresses, and no read is flagged until that frame is complete.

The address is combinational from the counters. It is valid in the same cycle as the strobe, and the RAM reads and writes at that address on the clock edge.

Top module: `rs_addr_gen`

## Requirements
- R1: While reset (rst_n low, active low) is asserted and in the first cycle after it, byte_idx is 0, frame_phase is 0, ram_addr is 0, and rd_en is 0 even when byte_stb is high.
- R2: Each clock edge with byte_stb high increments byte_idx by one, wrapping from 15 to 0.
- R3: frame_phase increments by one, modulo 4, on the edge where byte_idx wraps from 15 to 0, and at no other edge.
- R4: With byte_idx = 4c + r (c = byte_idx[3:2], r = byte_idx[1:0]), ram_addr equals 4·((c + frame_phase·r) mod 4) + r in the same cycle. Bits [1:0] of ram_addr are the row and bits [3:2] are the column.
- R5: In phase 0 the addresses are sequential: ram_addr equals byte_idx for bytes 0 to 15.
- R6: In phase 1 the first four addresses are 0, 5, 10 and 15.
- R7: rd_en is 0 for every strobe of the first frame after reset. From then on it equals byte_stb.
- R8: After four complete frames, frame_phase is 0 again and the address sequence is again 0 to 15.
- R9: A RAM written and read at ram_addr in the same cycle returns, at strobe k of frame f (f ≥ 1), byte P(k) of frame f−1, where P(k) = 4·((c + r) mod 4) + r. These are the row-shifted bytes of the previous frame.
- R10: With byte_stb low, byte_idx, frame_phase and ram_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_stb | input | 1 | One byte is moved this cycle |
| ram_addr | output | 4 | Shared read/write address for the state RAM |
| rd_en | output | 1 | Read data at ram_addr belongs to a previous frame |
| byte_idx | output | 4 | Position of the current byte within the frame |
| frame_phase | output | 2 | Frame count modulo 4 |

## Verification
The read of a byte of the old frame and the write of a byte of the new frame always happen in the same cycle and at the same address. The bench keeps its own RAM model: it checks the value read, then overwrites that location with the incoming byte before the clock edge. A wrong address in any phase shows up as a wrong row-shifted byte in a later frame. Gaps in the strobe are inserted in the middle of a frame, to confirm that the read-and-write pairing stays aligned across the gap.

// File: rtl/rs_addr_gen.sv
module rs_addr_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_stb,
  output logic [3:0] ram_addr,
  output logic       rd_en,
  output logic [3:0] byte_idx,
  output logic [1:0] frame_phase
);

  logic [3:0] idx_q;
  logic [1:0] phase_q;
  logic       primed_q;
  logic [1:0] col, row, skew;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q    <= '0;
      phase_q  <= '0;
      primed_q <= 1'b0;
    end else if (byte_stb) begin
      idx_q <= idx_q + 4'd1;
      if (idx_q == 4'd15) begin
        phase_q  <= phase_q + 2'd1;
        primed_q <= 1'b1;
      end
    end
  end

  assign col  = idx_q[3:2];
  assign row  = idx_q[1:0];
  assign skew = phase_q * row;

  assign ram_addr    = {col + skew, row};
  assign rd_en       = byte_stb & primed_q;
  assign byte_idx    = idx_q;
  assign frame_phase = phase_q;

endmodule

// File: rtl/rs_addr_gen_chk.sv
module rs_addr_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       byte_stb,
  input logic [3:0] ram_addr,
  input logic       rd_en,
  input logic [3:0] byte_idx,
  input logic [1:0] frame_phase
);

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> byte_idx == $past(byte_idx) + 4'd1);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_stb |=> $stable(byte_idx) && $stable(frame_phase) && $stable(ram_addr));

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_idx == 4'd15) |=> frame_phase == $past(frame_phase) + 2'd1);

  a_r3_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb && byte_idx != 4'd15) |=> $stable(frame_phase));

  a_r4_row: assert property (@(posedge clk) disable iff (!rst_n)
    ram_addr[1:0] == byte_idx[1:0]);

  a_r5_natural: assert property (@(posedge clk) disable iff (!rst_n)
    frame_phase == 2'd0 |-> ram_addr == byte_idx);

  a_r7_rd_gated: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> byte_stb);

endmodule

bind rs_addr_gen rs_addr_gen_chk u_chk (.*);

// File: tb/rs_addr_gen_bench.sv
`timescale 1ns/1ps
module rs_addr_gen_bench;
  logic clk = 1'b0, rst_n = 1'b0, byte_stb = 1'b0;
  logic [3:0] ram_addr, byte_idx;
  logic [1:0] frame_phase;
  logic       rd_en;

  rs_addr_gen u_rs_addr_gen (.clk(clk), .rst_n(rst_n), .byte_stb(byte_stb),
    .ram_addr(ram_addr), .rd_en(rd_en), .byte_idx(byte_idx), .frame_phase(frame_phase));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem [16];
  int m_idx = 0, m_phase = 0, frame_no = 0;
  bit m_primed = 0;

  function automatic int pstep(int k);
    return 4 * ((k / 4 + k % 4) % 4) + k % 4;
  endfunction

  function automatic int pn(int k, int n);
    int v = k;
    for (int i = 0; i < n; i++) v = pstep(v);
    return v;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (frame %0d byte %0d)", req, act, exp, frame_no, m_idx);
    end
  endtask

  task automatic one_byte();
    @(negedge clk);
    byte_stb = 1'b1;
    #1;
    chk("R2", byte_idx, m_idx);
    chk("R3", frame_phase, m_phase);
    chk("R4", ram_addr, pn(m_idx, m_phase));
    chk("R7", rd_en, m_primed);
    if (m_primed) chk("R9", mem[ram_addr], ((frame_no - 1) * 16 + pstep(m_idx)) & 255);
    mem[ram_addr] = 8'((frame_no * 16 + m_idx) & 255);
    @(posedge clk);
    #1;
    byte_stb = 1'b0;
    m_idx = (m_idx + 1) % 16;
    if (m_idx == 0) begin
      m_phase = (m_phase + 1) % 4;
      m_primed = 1;
      frame_no++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    byte_stb = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1", byte_idx, 0);
    chk("R1", frame_phase, 0);
    chk("R1", ram_addr, 0);
    @(negedge clk);
    rst_n = 1'b1;
    byte_stb = 1'b0;
    #1;
    chk("R1", rd_en, 0);
    chk("R1", byte_idx, 0);
    m_idx = 0; m_phase = 0; m_primed = 0; frame_no = 0;
  endtask

  task automatic t_fill();
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      chk("R5", ram_addr, k);
      one_byte();
    end
  endtask

  task automatic t_shift_start();
    int exp4[4] = '{0, 5, 10, 15};
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk("R6", ram_addr, exp4[k]);
      one_byte();
    end
    for (int k = 4; k < 16; k++) one_byte();
  endtask

  task automatic t_gaps();
    for (int k = 0; k < 16; k++) begin
      one_byte();
      if (k % 5 == 2) begin
        logic [3:0] a0 = ram_addr;
        repeat (3) @(posedge clk);
        #1;
        chk("R10", ram_addr, a0);
        chk("R10", byte_idx, m_idx);
        chk("R10", frame_phase, m_phase);
        chk("R7", rd_en, 0);
      end
    end
  endtask

  task automatic t_wrap();
    one_byte_frame();
    @(negedge clk); #1;
    chk("R8", frame_phase, 0);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); #1;
      chk("R8", ram_addr, k);
      one_byte();
    end
  endtask

  task automatic one_byte_frame();
    for (int k = 0; k < 16; k++) one_byte();
  endtask

  task automatic t_mid_reset();
    for (int k = 0; k < 7; k++) one_byte();
    do_reset();
    t_fill();
    one_byte_frame();
  endtask

  initial begin
    do_reset();
    t_fill();
    t_shift_start();
    t_gaps();
    t_wrap();
    for (int f = 0; f < 5; f++) one_byte_frame();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule